// File: doc/BRIEF.md
# Deferred Fault Flag Tracker

This block sits next to a register file and gives every architectural register one extra bit that marks its value as the result of a fault that was held back. A load issued ahead of its guarding branch may hit a fault. When it does, it does not trap. It writes its destination and sets that register's flag. Later operations may read such a register before anything checks it. Their results inherit the flag and raise nothing. A fault becomes visible only when an explicit check reaches the register. If the flag is clear, the check does nothing. If the flag is set, the check asks the front end to steer fetch to recovery code.

Each cycle the block accepts one result write, which carries a write kind and a fault indication, and serves two source-flag reads and one check. The pipeline uses the source-flag reads to see whether an operand is tainted. A check that finds its register flagged drives a single-cycle redirect that carries the recovery address the check supplied. A non-speculative load that faults raises an immediate trap pulse instead. Memory access and the recovery code belong to other blocks.

Top module: `spec_fault_tracker`

## Requirements
- R1: After reset every register's flag reads clear, and `redir_valid` and `trap_pulse` are low.
- R2: A write with `wr_kind` = 2'b01 (speculative load) and `wr_fault` high sets the destination flag and produces no trap pulse.
- R3: A write with `wr_kind` = 2'b01 and `wr_fault` low clears the destination flag.
- R4: A write with `wr_kind` = 2'b00 (plain), or the reserved code 2'b11, clears the destination flag. If `wr_fault` is also high, `trap_pulse` is high for exactly the next cycle.
- R5: A write with `wr_kind` = 2'b10 (derived) sets the destination flag to the OR of the selected source flags (read through ports A and B in the same cycle) and never raises a trap, whatever `wr_fault` is.
- R6: In a derived write, a source whose select bit (`wr_use_a` / `wr_use_b`) is low contributes nothing to the result flag.
- R7: A check on a register whose flag is clear leaves `redir_valid` low in the following cycle.
- R8: A check on a flagged register drives `redir_valid` high in the following cycle, with `redir_target` equal to the `chk_target` presented with the check.
- R9: A check never changes any register's flag.
- R10: Reads and checks see each flag as it stood before the write of the same cycle, so a same-register write takes effect one cycle later.
- R11: With `wr_en` low, no flag changes and no trap is raised, whatever the other write inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Result write valid |
| wr_addr | input | 6 | Destination register |
| wr_kind | input | 2 | 00 plain, 01 speculative load, 10 derived, 11 reserved (as plain) |
| wr_fault | input | 1 | The load producing this result faulted |
| wr_use_a | input | 1 | Derived write uses source A flag |
| wr_use_b | input | 1 | Derived write uses source B flag |
| rd_a_addr | input | 6 | Source A register |
| rd_b_addr | input | 6 | Source B register |
| rd_a_flag | output | 1 | Flag of source A (combinational) |
| rd_b_flag | output | 1 | Flag of source B (combinational) |
| chk_en | input | 1 | Check operation valid |
| chk_addr | input | 6 | Register being checked |
| chk_target | input | 32 | Recovery address carried by the check |
| redir_valid | output | 1 | One-cycle redirect request |
| redir_target | output | 32 | Recovery address for the redirect |
| trap_pulse | output | 1 | Immediate fault from a plain load |

## Verification
Directed sequences cover the main cases one at a time. A faulting speculative load is followed by a chain of derived writes, which shows that a flag travels through dependents and does not stop at the first consumer. Derived writes are repeated with each source select turned off in turn, which separates an OR of the selected flags from an OR of both read ports. Checks are issued on clean and tainted registers, with a write to the same register in the same cycle, which shows old-value visibility and that a check does not clear the flag. A long run of random writes, reads and checks is then compared on every clock against a behavioural flag array.

// File: rtl/sft_pkg.sv
package sft_pkg;

    typedef enum logic [1:0] {
        WK_PLAIN   = 2'b00,
        WK_SPEC_LD = 2'b01,
        WK_DERIVED = 2'b10,
        WK_RSVD    = 2'b11
    } wr_kind_e;

    typedef struct packed {
        logic     valid;
        wr_kind_e kind;
        logic     fault;
        logic     use_a;
        logic     use_b;
    } wr_ctl_t;

    typedef struct packed {
        logic upd;
        logic flag;
        logic trap;
    } wr_res_t;

    // Decide the new flag of the destination and whether a trap is due.
    function automatic wr_res_t resolve_write(wr_ctl_t c, logic src_a, logic src_b);
        wr_res_t r;
        r.upd  = c.valid;
        r.flag = 1'b0;
        r.trap = 1'b0;
        unique case (c.kind)
            WK_SPEC_LD: r.flag = c.fault;
            WK_DERIVED: r.flag = (c.use_a & src_a) | (c.use_b & src_b);
            default: begin
                r.flag = 1'b0;
                r.trap = c.valid & c.fault;
            end
        endcase
        return r;
    endfunction

endpackage

// File: rtl/sft_flag_store.sv
module sft_flag_store #(
    parameter int NUM_REGS = 64,
    localparam int AW = $clog2(NUM_REGS)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_upd,
    input  logic [AW-1:0]       wr_addr,
    input  logic                wr_flag,
    input  logic [AW-1:0]       rd_a_addr,
    input  logic [AW-1:0]       rd_b_addr,
    input  logic [AW-1:0]       chk_addr,
    output logic                rd_a_flag,
    output logic                rd_b_flag,
    output logic                chk_flag,
    output logic [NUM_REGS-1:0] flag_vec
);

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_flag
        logic q;
        logic hit;
        assign hit = wr_upd && (wr_addr == AW'(g));
        always_ff @(posedge clk) begin
            if (rst)      q <= 1'b0;
            else if (hit) q <= wr_flag;
        end
        assign flag_vec[g] = q;
    end

    assign rd_a_flag = flag_vec[rd_a_addr];
    assign rd_b_flag = flag_vec[rd_b_addr];
    assign chk_flag  = flag_vec[chk_addr];

endmodule

// File: rtl/sft_write_resolve.sv
module sft_write_resolve
    import sft_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  wr_ctl_t ctl,
    input  logic    src_a_flag,
    input  logic    src_b_flag,
    output logic    upd,
    output logic    new_flag,
    output logic    trap_q
);

    wr_res_t res;

    always_comb begin
        res = resolve_write(ctl, src_a_flag, src_b_flag);
    end

    assign upd      = res.upd;
    assign new_flag = res.flag;

    always_ff @(posedge clk) begin
        if (rst) trap_q <= 1'b0;
        else     trap_q <= res.trap;
    end

endmodule

// File: rtl/sft_check_unit.sv
module sft_check_unit #(
    parameter int TGT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             chk_en,
    input  logic             chk_flag,
    input  logic [TGT_W-1:0] chk_target,
    output logic             redir_valid,
    output logic [TGT_W-1:0] redir_target
);

    always_ff @(posedge clk) begin
        if (rst) begin
            redir_valid  <= 1'b0;
            redir_target <= '0;
        end else begin
            redir_valid <= chk_en & chk_flag;
            if (chk_en & chk_flag) redir_target <= chk_target;
        end
    end

endmodule

// File: rtl/spec_fault_tracker.sv
module spec_fault_tracker
    import sft_pkg::*;
#(
    parameter int NUM_REGS = 64,
    parameter int TGT_W    = 32,
    localparam int AW = $clog2(NUM_REGS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [1:0]       wr_kind,
    input  logic             wr_fault,
    input  logic             wr_use_a,
    input  logic             wr_use_b,
    input  logic [AW-1:0]    rd_a_addr,
    input  logic [AW-1:0]    rd_b_addr,
    output logic             rd_a_flag,
    output logic             rd_b_flag,
    input  logic             chk_en,
    input  logic [AW-1:0]    chk_addr,
    input  logic [TGT_W-1:0] chk_target,
    output logic             redir_valid,
    output logic [TGT_W-1:0] redir_target,
    output logic             trap_pulse
);

    wr_ctl_t             ctl;
    logic                upd;
    logic                new_flag;
    logic                chk_flag;
    logic [NUM_REGS-1:0] flag_vec;

    always_comb begin
        ctl.valid = wr_en;
        ctl.kind  = wr_kind_e'(wr_kind);
        ctl.fault = wr_fault;
        ctl.use_a = wr_use_a;
        ctl.use_b = wr_use_b;
    end

    sft_flag_store #(.NUM_REGS(NUM_REGS)) u_store (
        .clk       (clk),
        .rst       (rst),
        .wr_upd    (upd),
        .wr_addr   (wr_addr),
        .wr_flag   (new_flag),
        .rd_a_addr (rd_a_addr),
        .rd_b_addr (rd_b_addr),
        .chk_addr  (chk_addr),
        .rd_a_flag (rd_a_flag),
        .rd_b_flag (rd_b_flag),
        .chk_flag  (chk_flag),
        .flag_vec  (flag_vec)
    );

    sft_write_resolve u_resolve (
        .clk        (clk),
        .rst        (rst),
        .ctl        (ctl),
        .src_a_flag (rd_a_flag),
        .src_b_flag (rd_b_flag),
        .upd        (upd),
        .new_flag   (new_flag),
        .trap_q     (trap_pulse)
    );

    sft_check_unit #(.TGT_W(TGT_W)) u_check (
        .clk          (clk),
        .rst          (rst),
        .chk_en       (chk_en),
        .chk_flag     (chk_flag),
        .chk_target   (chk_target),
        .redir_valid  (redir_valid),
        .redir_target (redir_target)
    );

endmodule

// File: rtl/spec_fault_tracker_checker.sv
module spec_fault_tracker_checker #(
    parameter int NUM_REGS = 64,
    parameter int TGT_W    = 32,
    localparam int AW = $clog2(NUM_REGS)
) (
    input logic                clk,
    input logic                rst,
    input logic                wr_en,
    input logic [AW-1:0]       wr_addr,
    input logic [1:0]          wr_kind,
    input logic                wr_fault,
    input logic                chk_en,
    input logic [AW-1:0]       chk_addr,
    input logic [TGT_W-1:0]    chk_target,
    input logic                redir_valid,
    input logic [TGT_W-1:0]    redir_target,
    input logic                trap_pulse,
    input logic [NUM_REGS-1:0] flag_vec
);

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (flag_vec == '0 && !redir_valid && !trap_pulse));

    assert_spec_fault_sets_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_kind == 2'b01 && wr_fault) |=> flag_vec[$past(wr_addr)]);

    assert_plain_clears_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (wr_kind == 2'b00 || wr_kind == 2'b11)) |=> !flag_vec[$past(wr_addr)]);

    assert_trap_only_plain_R5: assert property (@(posedge clk) disable iff (rst)
        trap_pulse |-> $past(wr_en && wr_fault && (wr_kind == 2'b00 || wr_kind == 2'b11)));

    assert_no_redir_clean_R7: assert property (@(posedge clk) disable iff (rst)
        (chk_en && !flag_vec[chk_addr]) |=> !redir_valid);

    assert_redir_target_R8: assert property (@(posedge clk) disable iff (rst)
        redir_valid |-> ($past(chk_en) && redir_target == $past(chk_target)));

    assert_idle_stable_R11: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(flag_vec));

endmodule

bind spec_fault_tracker spec_fault_tracker_checker #(
    .NUM_REGS (NUM_REGS),
    .TGT_W    (TGT_W)
) u_checker (
    .clk          (clk),
    .rst          (rst),
    .wr_en        (wr_en),
    .wr_addr      (wr_addr),
    .wr_kind      (wr_kind),
    .wr_fault     (wr_fault),
    .chk_en       (chk_en),
    .chk_addr     (chk_addr),
    .chk_target   (chk_target),
    .redir_valid  (redir_valid),
    .redir_target (redir_target),
    .trap_pulse   (trap_pulse),
    .flag_vec     (flag_vec)
);

// File: tb/spec_fault_tracker_test.sv
module spec_fault_tracker_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en, wr_fault, wr_use_a, wr_use_b;
    logic [5:0]  wr_addr, rd_a_addr, rd_b_addr, chk_addr;
    logic [1:0]  wr_kind;
    logic        rd_a_flag, rd_b_flag;
    logic        chk_en;
    logic [31:0] chk_target;
    logic        redir_valid;
    logic [31:0] redir_target;
    logic        trap_pulse;

    int errors = 0;
    int checks = 0;
    bit model [64];
    bit done = 1'b0;

    always #10 clk = ~clk;

    spec_fault_tracker uut (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_kind(wr_kind), .wr_fault(wr_fault),
        .wr_use_a(wr_use_a), .wr_use_b(wr_use_b),
        .rd_a_addr(rd_a_addr), .rd_b_addr(rd_b_addr),
        .rd_a_flag(rd_a_flag), .rd_b_flag(rd_b_flag),
        .chk_en(chk_en), .chk_addr(chk_addr), .chk_target(chk_target),
        .redir_valid(redir_valid), .redir_target(redir_target),
        .trap_pulse(trap_pulse)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle();
        wr_en = 0; wr_addr = 0; wr_kind = 0; wr_fault = 0; wr_use_a = 0; wr_use_b = 0;
        rd_a_addr = 0; rd_b_addr = 0; chk_en = 0; chk_addr = 0; chk_target = 0;
    endtask

    // Inputs are set; compare reads, step one clock, compare registered outputs.
    task automatic tick(string tag);
        bit nf, etrap, eredir;
        logic [31:0] etgt;
        #1;
        check({tag, " rdA"}, rd_a_flag, model[rd_a_addr]);
        check({tag, " rdB"}, rd_b_flag, model[rd_b_addr]);
        nf = 0; etrap = 0;
        if (wr_kind == 2'b01)      nf = wr_fault;
        else if (wr_kind == 2'b10) nf = (wr_use_a & model[rd_a_addr]) | (wr_use_b & model[rd_b_addr]);
        else                       etrap = wr_en & wr_fault;
        eredir = chk_en & model[chk_addr];
        etgt = chk_target;
        @(posedge clk);
        #2;
        if (wr_en) model[wr_addr] = nf;
        check({tag, " redir"}, redir_valid, eredir);
        if (eredir) check({tag, " tgt"}, redir_target, etgt);
        check({tag, " trap"}, trap_pulse, etrap);
    endtask

    task automatic wr(logic [5:0] a, logic [1:0] k, logic f, logic ua, logic ub,
                      logic [5:0] sa, logic [5:0] sb, string tag);
        idle();
        wr_en = 1; wr_addr = a; wr_kind = k; wr_fault = f; wr_use_a = ua; wr_use_b = ub;
        rd_a_addr = sa; rd_b_addr = sb;
        tick(tag);
    endtask

    task automatic chk(logic [5:0] a, logic [31:0] t, string tag);
        idle();
        chk_en = 1; chk_addr = a; chk_target = t;
        tick(tag);
    endtask

    task automatic peek(logic [5:0] a, bit exp, string tag);
        idle();
        rd_a_addr = a;
        #1;
        check(tag, rd_a_flag, exp);
    endtask

    initial begin
        #1000000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        idle();
        rst = 1;
        repeat (3) @(posedge clk);
        #2;
        rst = 0;
        check("R1 redir", redir_valid, 0);
        check("R1 trap", trap_pulse, 0);
        for (int i = 0; i < 32; i++) begin
            idle();
            rd_a_addr = 6'(2 * i); rd_b_addr = 6'(2 * i + 1);
            tick("R1");
        end

        // R2: faulting speculative load taints r5, no trap
        wr(6'd5, 2'b01, 1, 0, 0, 0, 0, "R2");
        peek(6'd5, 1, "R2 flag");
        // R5: chain r5 -> r6 -> r7, fault input ignored
        wr(6'd6, 2'b10, 1, 1, 0, 6'd5, 6'd0, "R5");
        wr(6'd7, 2'b10, 0, 0, 1, 6'd1, 6'd6, "R5");
        peek(6'd7, 1, "R5 chain");
        // R6: selected clean source, tainted unselected source
        wr(6'd8, 2'b10, 0, 1, 0, 6'd2, 6'd5, "R6");
        peek(6'd8, 0, "R6 unselB");
        wr(6'd9, 2'b10, 0, 0, 1, 6'd5, 6'd2, "R6");
        peek(6'd9, 0, "R6 unselA");
        // R7: check clean register
        chk(6'd8, 32'hDEAD_0000, "R7");
        // R8 and R9: check tainted, twice
        chk(6'd7, 32'h1234_5678, "R8");
        chk(6'd7, 32'h0BAD_CAFE, "R9");
        peek(6'd7, 1, "R9 kept");
        // R11: write disabled
        idle();
        wr_addr = 6'd7; wr_kind = 2'b00; wr_fault = 1; tick("R11");
        peek(6'd7, 1, "R11 kept");
        // R10: write clears r7 while read and check see old value
        idle();
        wr_en = 1; wr_addr = 6'd7; wr_kind = 2'b00; rd_a_addr = 6'd7;
        chk_en = 1; chk_addr = 6'd7; chk_target = 32'hAAAA_5555;
        tick("R10");
        peek(6'd7, 0, "R10 after");
        // R4: plain faulting load traps and clears; reserved acts as plain
        wr(6'd5, 2'b00, 1, 0, 0, 0, 0, "R4");
        peek(6'd5, 0, "R4 flag");
        wr(6'd6, 2'b11, 1, 0, 0, 0, 0, "R4 rsvd");
        peek(6'd6, 0, "R4 rsvd flag");
        // R3: spec load without fault clears
        wr(6'd9, 2'b01, 1, 0, 0, 0, 0, "R3 set");
        wr(6'd9, 2'b01, 0, 0, 0, 0, 0, "R3");
        peek(6'd9, 0, "R3 flag");

        // Mixed traffic against the model
        for (int n = 0; n < 3000; n++) begin
            idle();
            wr_en = ($urandom % 4) != 0;
            wr_addr = 6'($urandom % 16);
            wr_kind = 2'($urandom);
            wr_fault = ($urandom % 3) == 0;
            wr_use_a = 1'($urandom); wr_use_b = 1'($urandom);
            rd_a_addr = 6'($urandom % 16); rd_b_addr = 6'($urandom % 16);
            chk_en = 1'($urandom); chk_addr = 6'($urandom % 16);
            chk_target = $urandom;
            tick("R10 mix");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule